// File: doc/BRIEF.md
# NAND Flash Host Command-Cycle Controller

This block is the host side of an 8-bit multiplexed NAND flash bus. A client places one request at a time on a small request port: an operation code, a 22-bit byte address and a byte count. The controller turns it into the bus cycles the flash expects. These are command bytes with the command latch high, address bytes with the address latch high, and write data bytes, all strobed by write-enable pulses. It then counts the mandatory wait after an operation starts, polls the ready/busy line and fetches read data with read-enable pulses. Every strobe width and gap is a clock count set by a parameter.

Program data is pulled from the client one byte per `wr_take` pulse. Read, ID and status bytes are returned with a one-cycle `rd_valid` strobe. After a program or erase, the controller issues a status read by itself and latches bit 0 of the returned byte as the pass/fail result. The chip enable is held low for the whole of an operation and released when it ends. `done` pulses once at the end of every operation.

Operation codes on `req_op`: 0 page read, 1 spare-area read, 2 page program, 3 block erase, 4 status read, 5 ID read, 6 reset. Code 7 behaves as a status read.

Top module: `nand_cmd_seq`

## Requirements
- R1: During and after reset, and whenever no operation is running, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, and `req_ready` is high.
- R2: A page read (op 0) sends command 00h when address bit 8 is 0 and 01h when it is 1. It then sends three address bytes: bits 7..0, bits 16..9, and {000, bits 21..17}. After ready it returns `req_len` bytes in bus order on `rd_data`.
- R3: A spare read (op 1) sends command 50h followed by the same three address bytes as R2, then returns `req_len` bytes.
- R4: A page program (op 2) sends 80h, the three address bytes of R2, `req_len` data bytes taken in order from `wr_data` (one `wr_take` pulse per byte), and then 10h. After ready it sends 70h, reads one status byte onto `rd_data`, and sets `status_fail` to that byte's bit 0.
- R5: A block erase (op 3) sends 60h, only the two row bytes (bits 16..9, then {000, bits 21..17}), and D0h. After ready it sends 70h and latches status bit 0 into `status_fail`.
- R6: Each write-enable pulse stays low for at least T_WP clocks and high for at least T_WH clocks between pulses, and a full write cycle is at least 50 ns. The latch enables and the driven data stay unchanged from the write-enable fall through its rise.
- R7: Each read-enable pulse stays low for at least T_RP clocks, with at least T_REH clocks high between pulses. Input data is captured at the end of the low phase.
- R8: The ready/busy input is ignored for T_WB clocks after the write pulse that starts a busy period. The next strobe comes only after the line reads ready, and the first read-enable fall comes at least T_RR clocks after ready.
- R9: A status read (op 4, or the one that follows a program or erase) sends 70h. Its read-enable fall comes at least T_WHR clocks after the last write-enable rise.
- R10: An ID read (op 5) sends 90h and one address byte 00h. It waits at least T_AR clocks before the first read-enable fall and then returns `req_len` bytes.
- R11: A reset (op 6) sends FFh alone, waits for the busy period to end, and only then pulses `done`.
- R12: `nand_dq_oe` is high only during command, address and write-data cycles, and it is never high while `nand_re_n` is low.
- R13: `done` is a single-cycle pulse issued once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_op | input | 3 | Operation code |
| req_addr | input | 22 | Byte address (column, half select, row) |
| req_len | input | LEN_W | Number of data bytes to write or read |
| req_ready | output | 1 | Controller idle and able to accept a request |
| wr_data | input | 8 | Next program data byte |
| wr_take | output | 1 | Current `wr_data` byte consumed |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | Operation finished |
| status_fail | output | 1 | Bit 0 of the last status byte read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus data driven to the flash |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data from the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
A wrong sequencer state shows on the bus within one write or read cycle. The bench records every latched byte with its kind (command, address or data) and compares the whole list against the expected sequence for the operation, so a misplaced opcode, an address byte out of order or a missing byte is reported when the operation ends. Timing slips are caught at the offending edge: a short strobe pulse, data changing while write enable is low, or a read strobe during busy or too soon after ready or after the status command. Early sampling of ready/busy shows as a strobe while the line is low, or as `done` arriving before the busy period ends.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int T_WP  = 6,
  parameter int T_WH  = 4,
  parameter int T_RP  = 8,
  parameter int T_REH = 3,
  parameter int T_WB  = 20,
  parameter int T_RR  = 4,
  parameter int T_WHR = 12,
  parameter int T_AR  = 30,
  parameter int LEN_W = 10,
  parameter int CW    = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [21:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             status_fail,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb
);

  localparam logic [2:0] OP_READ = 3'd0, OP_SPARE = 3'd1, OP_PROG = 3'd2,
                         OP_ERASE = 3'd3, OP_ID = 3'd5, OP_RESET = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDAT, S_CMD2, S_BUSY, S_SCMD, S_GAP, S_RDAT, S_DONE
  } state_t;

  state_t           st;
  logic [2:0]       op;
  logic [21:0]      addr;
  logic [LEN_W-1:0] len, idx;
  logic [CW-1:0]    cnt, gap_lim;
  logic             ph, stat;
  logic [1:0]       rb_s;
  logic [7:0]       cmd1, abyte;
  logic             wr_cyc, wend, is_read;

  assign is_read = (op == OP_READ) || (op == OP_SPARE);
  assign wr_cyc  = (st == S_CMD) || (st == S_ADDR) || (st == S_WDAT) ||
                   (st == S_CMD2) || (st == S_SCMD);
  assign wend    = wr_cyc && ph && (cnt == CW'(T_WH - 1));

  assign req_ready  = (st == S_IDLE);
  assign nand_ce_n  = (st == S_IDLE);
  assign nand_cle   = (st == S_CMD) || (st == S_CMD2) || (st == S_SCMD);
  assign nand_ale   = (st == S_ADDR);
  assign nand_we_n  = !(wr_cyc && !ph);
  assign nand_re_n  = !((st == S_RDAT) && !ph);
  assign nand_dq_oe = wr_cyc;
  assign wr_take    = (st == S_WDAT) && wend;

  always_comb begin
    case (op)
      OP_READ:  cmd1 = addr[8] ? 8'h01 : 8'h00;
      OP_SPARE: cmd1 = 8'h50;
      OP_PROG:  cmd1 = 8'h80;
      OP_ERASE: cmd1 = 8'h60;
      OP_ID:    cmd1 = 8'h90;
      OP_RESET: cmd1 = 8'hFF;
      default:  cmd1 = 8'h70;
    endcase
    if (op == OP_ID)       abyte = 8'h00;
    else if (idx == '0)    abyte = addr[7:0];
    else if (idx == LEN_W'(1)) abyte = addr[16:9];
    else                   abyte = {3'b000, addr[21:17]};
    if (stat)              gap_lim = CW'(T_WHR);
    else if (op == OP_ID)  gap_lim = CW'(T_AR);
    else                   gap_lim = CW'(T_RR);
  end

  always_comb begin
    case (st)
      S_CMD:   nand_dq_o = cmd1;
      S_ADDR:  nand_dq_o = abyte;
      S_WDAT:  nand_dq_o = wr_data;
      S_CMD2:  nand_dq_o = (op == OP_PROG) ? 8'h10 : 8'hD0;
      S_SCMD:  nand_dq_o = 8'h70;
      default: nand_dq_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; addr <= '0; len <= '0; idx <= '0;
      cnt <= '0; ph <= 1'b0; stat <= 1'b0; rb_s <= 2'b00;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; status_fail <= 1'b0;
    end else begin
      rb_s     <= {rb_s[0], nand_rb};
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (wr_cyc) begin
        if (!ph) begin
          if (cnt == CW'(T_WP - 1)) begin ph <= 1'b1; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end else if (!wend) begin
          cnt <= cnt + 1'b1;
        end else begin
          ph <= 1'b0; cnt <= '0;
          case (st)
            S_CMD: begin
              idx <= (op == OP_ERASE) ? LEN_W'(1) : '0;
              if (op == OP_RESET) st <= S_BUSY;
              else if (is_read || op == OP_PROG || op == OP_ERASE || op == OP_ID) st <= S_ADDR;
              else begin stat <= 1'b1; st <= S_GAP; end
            end
            S_ADDR: begin
              if (op == OP_ID || idx == LEN_W'(2)) begin
                idx <= '0;
                if (is_read) st <= S_BUSY;
                else if (op == OP_PROG) st <= (len == '0) ? S_CMD2 : S_WDAT;
                else if (op == OP_ERASE) st <= S_CMD2;
                else st <= S_GAP;
              end else idx <= idx + 1'b1;
            end
            S_WDAT: begin
              if (idx == len - LEN_W'(1)) st <= S_CMD2;
              else idx <= idx + 1'b1;
            end
            S_CMD2: st <= S_BUSY;
            default: begin stat <= 1'b1; st <= S_GAP; end
          endcase
        end
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            op <= req_op; addr <= req_addr; len <= req_len;
            stat <= 1'b0; ph <= 1'b0; cnt <= '0; idx <= '0; st <= S_CMD;
          end
          S_BUSY: begin
            if (cnt < CW'(T_WB)) cnt <= cnt + 1'b1;
            else if (rb_s[1]) begin
              cnt <= '0;
              if (op == OP_RESET) st <= S_DONE;
              else if (is_read) st <= S_GAP;
              else st <= S_SCMD;
            end
          end
          S_GAP: begin
            if (!stat && len == '0) st <= S_DONE;
            else if (cnt >= gap_lim - 1'b1) begin
              cnt <= '0; ph <= 1'b0; idx <= '0; st <= S_RDAT;
            end else cnt <= cnt + 1'b1;
          end
          S_RDAT: begin
            if (!ph) begin
              if (cnt == CW'(T_RP - 1)) begin
                ph <= 1'b1; cnt <= '0;
                rd_data <= nand_dq_i; rd_valid <= 1'b1;
                if (stat) status_fail <= nand_dq_i[0];
              end else cnt <= cnt + 1'b1;
            end else if (cnt == CW'(T_REH - 1)) begin
              ph <= 1'b0; cnt <= '0;
              if (stat || idx == len - LEN_W'(1)) st <= S_DONE;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_DONE: begin done <= 1'b1; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [CW-1:0] we_lo, re_lo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin we_lo <= '0; re_lo <= '0; end
    else begin
      we_lo <= nand_we_n ? '0 : ((we_lo == '1) ? we_lo : we_lo + 1'b1);
      re_lo <= nand_re_n ? '0 : ((re_lo == '1) ? re_lo : re_lo + 1'b1);
    end
  end

  a_r6_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> we_lo >= CW'(T_WP));
  a_r7_re_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> re_lo >= CW'(T_RP));
  a_r6_dq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)));
  a_r12_oe_off_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_dq_oe && nand_we_n));
  a_r6_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n && !nand_dq_oe));
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int T_WP = 6, T_WH = 4, T_RP = 8, T_REH = 3, T_WB = 20;
  localparam int T_RR = 4, T_WHR = 12, T_AR = 30, LEN_W = 10;
  localparam real P = 5.0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, wr_take, rd_valid, done, status_fail;
  logic [2:0] req_op;
  logic [21:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [7:0] wr_data, rd_data, nand_dq_o;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] dq_i = 8'h5A;
  logic rb = 1'b1;

  nand_cmd_seq #(.T_WP(T_WP), .T_WH(T_WH), .T_RP(T_RP), .T_REH(T_REH), .T_WB(T_WB),
    .T_RR(T_RR), .T_WHR(T_WHR), .T_AR(T_AR), .LEN_W(LEN_W), .CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .status_fail(status_fail),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(dq_i), .nand_rb(rb));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", what, act, exp); end
  endtask

  function automatic logic [7:0] dpat(input int k);  return 8'(k * 13 + 5);  endfunction
  function automatic logic [7:0] idpat(input int k); return (k == 0) ? 8'h3C : 8'(8'h7E + k); endfunction
  function automatic logic [7:0] wpat(input int k);  return 8'(k * 29 + 3);  endfunction

  int wi = 0;
  assign wr_data = wpat(wi);
  always @(negedge clk) if (wr_take) wi <= wi + 1;

  int rbuf [0:4095];
  int nrd = 0;
  always @(negedge clk) if (rd_valid) begin rbuf[nrd % 4096] = rd_data; nrd++; end

  int lk [0:4095];
  int lv [0:4095];
  int n_log = 0;
  int mode = 0, acnt = 0, kidx = 0;
  bit fail_bit = 0, after_busy = 0, have_we = 0, have_re = 0, stat_first = 0;
  int busy_ns = 300;
  realtime t_wf = 0, t_wr = 0, t_rf = 0, t_rr = 0, t_rbr = 0;
  logic s_cle, s_ale;
  logic [7:0] s_dq;
  event go_busy;

  always begin
    @(go_busy);
    #40; rb = 1'b0;
    #(busy_ns); rb = 1'b1; t_rbr = $realtime;
  end

  always @(negedge nand_we_n) if (!nand_ce_n) begin
    if (have_we) begin
      chk($realtime - t_wr >= T_WH * P - 0.01, "R6 WE high time", int'($realtime - t_wr), int'(T_WH * P));
      chk($realtime - t_wf >= 49.99, "R6 write cycle", int'($realtime - t_wf), 50);
    end
    if (after_busy) begin chk(rb == 1'b1, "R8 strobe while busy", rb, 1); after_busy = 0; end
    t_wf = $realtime; have_we = 1;
    #1; s_cle = nand_cle; s_ale = nand_ale; s_dq = nand_dq_o;
  end

  always @(posedge nand_we_n) if (!nand_ce_n) begin
    int kind;
    chk($realtime - t_wf >= T_WP * P - 0.01, "R6 WE low time", int'($realtime - t_wf), int'(T_WP * P));
    chk(s_cle == nand_cle && s_ale == nand_ale && s_dq == nand_dq_o && nand_dq_oe,
        "R6 latch/data held through WE low", int'(nand_dq_o), int'(s_dq));
    t_wr = $realtime;
    kind = nand_cle ? 1 : (nand_ale ? 2 : 3);
    lk[n_log % 4096] = kind; lv[n_log % 4096] = nand_dq_o; n_log++;
    if (kind == 1) begin
      case (nand_dq_o)
        8'h00, 8'h01, 8'h50: begin mode = 1; acnt = 0; kidx = 0; end
        8'h80: mode = 4;
        8'h60: mode = 5;
        8'h70: begin mode = 2; kidx = 0; stat_first = 1; end
        8'h90: begin mode = 3; kidx = 0; end
        8'h10, 8'hD0, 8'hFF: begin mode = 0; after_busy = 1; ->go_busy; end
        default: ;
      endcase
    end else if (kind == 2 && mode == 1) begin
      acnt++;
      if (acnt == 3) begin after_busy = 1; ->go_busy; end
    end
  end

  always @(posedge nand_re_n) if (!nand_ce_n) begin
    chk($realtime - t_rf >= T_RP * P - 0.01, "R7 RE low time", int'($realtime - t_rf), int'(T_RP * P));
    t_rr = $realtime;
  end

  always @(negedge nand_re_n) if (!nand_ce_n) begin
    logic [7:0] val;
    chk(!nand_dq_oe, "R12 bus driven during RE low", nand_dq_oe, 0);
    if (have_re)
      chk($realtime - t_rr >= T_REH * P - 0.01, "R7 RE high time", int'($realtime - t_rr), int'(T_REH * P));
    if (after_busy) begin
      chk(rb == 1'b1, "R8 RE while busy", rb, 1);
      chk($realtime - t_rbr >= T_RR * P - 0.01, "R8 ready to RE gap", int'($realtime - t_rbr), int'(T_RR * P));
      after_busy = 0;
    end
    if (mode == 2 && stat_first)
      chk($realtime - t_wr >= T_WHR * P - 0.01, "R9 WE high to status RE", int'($realtime - t_wr), int'(T_WHR * P));
    if (mode == 3 && kidx == 0)
      chk($realtime - t_wr >= T_AR * P - 0.01, "R10 address to ID RE", int'($realtime - t_wr), int'(T_AR * P));
    stat_first = 0;
    t_rf = $realtime; have_re = 1;
    case (mode)
      1: val = dpat(kidx);
      2: val = {2'b11, 5'b0, fail_bit};
      3: val = idpat(kidx);
      default: val = 8'h00;
    endcase
    kidx++;
    dq_i = 8'h5A;
    #30; dq_i = val;
  end

  int ek [0:63];
  int ev [0:63];
  int en;
  task automatic push(input int k, input logic [7:0] v); ek[en] = k; ev[en] = v; en++; endtask

  task automatic do_op(input int op, input logic [21:0] a, input int len, input bit fb);
    int l0, r0, w0, dn, nexp;
    string tag;
    realtime t0;
    l0 = n_log; r0 = nrd; w0 = wi; dn = 0; fail_bit = fb; t0 = $realtime;
    busy_ns = 150 + int'($urandom % 1500);
    case (op)
      0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
      4: tag = "R9"; 5: tag = "R10"; default: tag = "R11";
    endcase
    @(negedge clk);
    req_op = 3'(op); req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R13 done single pulse", done, 0);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe && req_ready, "R1 idle after op", nand_ce_n, 1);
    en = 0;
    case (op)
      0, 1: begin
        push(1, op == 1 ? 8'h50 : (a[8] ? 8'h01 : 8'h00));
        push(2, a[7:0]); push(2, a[16:9]); push(2, {3'b000, a[21:17]});
      end
      2: begin
        push(1, 8'h80); push(2, a[7:0]); push(2, a[16:9]); push(2, {3'b000, a[21:17]});
        for (int i = 0; i < len; i++) push(3, wpat(w0 + i));
        push(1, 8'h10); push(1, 8'h70);
      end
      3: begin push(1, 8'h60); push(2, a[16:9]); push(2, {3'b000, a[21:17]}); push(1, 8'hD0); push(1, 8'h70); end
      4: push(1, 8'h70);
      5: begin push(1, 8'h90); push(2, 8'h00); end
      default: push(1, 8'hFF);
    endcase
    chk(n_log - l0 == en, {tag, " bus byte count"}, n_log - l0, en);
    for (int i = 0; i < en && i < n_log - l0; i++)
      chk(lk[(l0 + i) % 4096] == ek[i] && lv[(l0 + i) % 4096] == ev[i], {tag, " bus byte"},
          lk[(l0 + i) % 4096] * 256 + lv[(l0 + i) % 4096], ek[i] * 256 + ev[i]);
    nexp = (op == 0 || op == 1 || op == 5) ? len : ((op == 6) ? 0 : 1);
    chk(nrd - r0 == nexp, {tag, " read byte count"}, nrd - r0, nexp);
    for (int i = 0; i < nexp && i < nrd - r0; i++) begin
      int e;
      e = (op == 5) ? idpat(i) : ((op <= 1) ? dpat(i) : {2'b11, 5'b0, fb});
      chk(rbuf[(r0 + i) % 4096] == e, {tag, " read data"}, rbuf[(r0 + i) % 4096], e);
    end
    if (op == 2 || op == 3) chk(status_fail == fb, {tag, " status result"}, status_fail, fb);
    if (op == 2) chk(wi - w0 == len, "R4 wr_take count", wi - w0, len);
    if (op == 6) chk(t_rbr > t0, "R11 done after busy ends", int'(t_rbr), int'(t0));
  endtask

  bit finished = 0;
  initial begin
    #950000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R13 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'd4242);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0;
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
        "R1 pins in reset", {nand_ce_n, nand_we_n, nand_re_n}, 7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && nand_ce_n && !done, "R1 idle after reset", req_ready, 1);

    do_op(0, 22'h000105, 4, 0);
    do_op(0, 22'h3FFFFF, 3, 0);
    do_op(0, 22'h2A5E0C, 1, 0);
    do_op(1, 22'h01020A, 5, 0);
    do_op(2, 22'h155000, 6, 1);
    do_op(2, 22'h0000FF, 0, 0);
    do_op(3, 22'h3FFE00, 0, 0);
    do_op(3, 22'h012345, 0, 1);
    do_op(4, 22'h0, 0, 1);
    do_op(5, 22'h0, 2, 0);
    do_op(6, 22'h0, 0, 0);
    for (int n = 0; n < 40; n++) begin
      int op, len;
      op = int'($urandom % 7);
      len = (op == 2) ? int'($urandom % 13) : 1 + int'($urandom % 12);
      do_op(op, 22'($urandom), len, 1'($urandom));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule